// File: doc/BRIEF.md
# Sub-Row Array Access Sequencer

This block drives the row-side controls of one memory array built from two-port cells that have a separate read port. A request carries an operation (read or write), a row address, a sub-row select and, for writes, one sub-row of data. The block decodes the row once and shares that decode between sub-rows. It gates the write word-line and the cell-supply collapse enable per sub-row. Each access is split into two clock phases. The clock runs at twice the access rate, so the first phase is the first half of the access and the second phase is the evaluate half.

A write lowers the shared supply of the selected sub-row during the first phase only. The write word-line is held through both phases, and the new data lands at the end of the second phase. A read precharges the read bit-lines during the first phase. In the evaluate phase it enables the row's read word-line and pulls that row's read-buffer foot low, and every other foot stays high. The bit-lines then discharge fully, and the block registers the selected sub-row's word at the end of the evaluate phase. The storage cells are a behavioural array inside the block. Every cell of a sub-row is written or read together; there is no column interleave.

Top module: `sra_access_top`

## Requirements
- R1: After reset every word-line, foot and supply-collapse output is 0, the precharge output is 1 and the read-valid output is 0.
- R2: For a write to (row r, sub-row s), the first phase drives only write word-line bit r*SUBS+s and only collapse bit r*SUBS+s. The second phase keeps that word-line bit alone and drives every collapse bit to 0.
- R3: For a read of row r, the first phase drives precharge high with no word-line active. The evaluate phase drives only read word-line bit r and only foot-low bit r, with precharge low.
- R4: Precharge is never high in a clock where any write or read word-line bit is high.
- R5: In each clock, each of the write word-line, read word-line, foot-low and collapse vectors has at most one bit set.
- R6: Foot-low bits are 0 for every unselected row, and they are all 0 during writes and idle clocks.
- R7: A read raises the read-valid output for exactly one clock, starting at the edge that ends its evaluate phase. In that clock the read-data output carries the word last written to that (row, sub-row).
- R8: A write replaces all SUB_W bits of the selected sub-row. It leaves the other sub-rows of the same row and all other rows unchanged.
- R9: In a clock with no access in progress, all row controls are 0 and precharge is 1.
- R10: A request that is presented only while an access is in its first phase is ignored.
- R11: A request presented during an evaluate phase starts the next access in the following clock, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock (two clocks per access) |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Access request present |
| req_wr | input | 1 | 1 = write, 0 = read |
| row_addr | input | ROW_W | Row index |
| sub_sel | input | SEL_W | Sub-row index within the row |
| wdata | input | SUB_W | Write data for one sub-row |
| wwl_o | output | ROWS*SUBS | Write word-line per (row, sub-row), bit row*SUBS+sub |
| collapse_o | output | ROWS*SUBS | Cell-supply collapse enable per (row, sub-row) |
| rwl_o | output | ROWS | Read word-line per row |
| foot_low_o | output | ROWS | Read-buffer foot pull-down per row |
| prech_o | output | 1 | Read bit-line precharge |
| rdata_o | output | SUB_W | Registered read word |
| rvalid_o | output | 1 | Read data valid strobe |

## Verification
The hardest case to reach from the ports is an access whose request arrives while the previous access is still in progress. This covers both a request that lands only in a first phase and must be dropped, and one that lands in an evaluate phase and must chain directly. The stimulus reaches these cases by timing requests to chosen negative clock edges inside an access. A write followed immediately by a read of the same word then shows that the data committed at the end of the evaluate phase is visible to the chained read. An exhaustive write and read sweep over every row and sub-row, plus partial rewrites, exposes any leakage of data between sub-rows.

// File: rtl/sra_pkg.sv
package sra_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FIRST = 2'd1,
        PH_EVAL  = 2'd2
    } phase_e;
endpackage

// File: rtl/sra_onehot_dec.sv
module sra_onehot_dec #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic          en,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  hot
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign hot[i] = en && (idx == IW'(i));
    end
endmodule

// File: rtl/sra_phase_seq.sv
module sra_phase_seq
    import sra_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int SEL_W = 1,
    parameter int SUB_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_vld,
    input  logic             req_wr,
    input  logic [ROW_W-1:0] row_addr,
    input  logic [SEL_W-1:0] sub_sel,
    input  logic [SUB_W-1:0] wdata,
    input  logic [SUB_W-1:0] rbl_sel,
    output logic             ph_first,
    output logic             ph_eval,
    output logic             op_wr,
    output logic [ROW_W-1:0] row_q,
    output logic [SEL_W-1:0] sub_q,
    output logic [SUB_W-1:0] wdata_q,
    output logic [SUB_W-1:0] rdata,
    output logic             rvalid
);
    typedef struct packed {
        phase_e             ph;
        logic               wr;
        logic [ROW_W-1:0]   row;
        logic [SEL_W-1:0]   sub;
        logic [SUB_W-1:0]   wd;
        logic [SUB_W-1:0]   rd;
        logic               rv;
    } seq_t;

    seq_t s_d, s_q;
    logic accept;

    always_comb begin
        s_d    = s_q;
        s_d.rv = 1'b0;
        if (s_q.ph == PH_EVAL && !s_q.wr) begin
            s_d.rv = 1'b1;
            s_d.rd = rbl_sel;
        end
        accept = req_vld && (s_q.ph != PH_FIRST);
        if (accept) begin
            s_d.ph  = PH_FIRST;
            s_d.wr  = req_wr;
            s_d.row = row_addr;
            s_d.sub = sub_sel;
            s_d.wd  = wdata;
        end else if (s_q.ph == PH_FIRST) begin
            s_d.ph = PH_EVAL;
        end else begin
            s_d.ph = PH_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ph_first = (s_q.ph == PH_FIRST);
    assign ph_eval  = (s_q.ph == PH_EVAL);
    assign op_wr    = s_q.wr;
    assign row_q    = s_q.row;
    assign sub_q    = s_q.sub;
    assign wdata_q  = s_q.wd;
    assign rdata    = s_q.rd;
    assign rvalid   = s_q.rv;

    // R10
    first_to_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_FIRST) |=> (s_q.ph == PH_EVAL));
    // R11
    eval_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_EVAL && req_vld) |=> (s_q.ph == PH_FIRST));
endmodule

// File: rtl/sra_cell_array.sv
module sra_cell_array #(
    parameter int ROWS  = 16,
    parameter int SUBS  = 2,
    parameter int SUB_W = 8
) (
    input  logic                          clk,
    input  logic [ROWS*SUBS-1:0]          wwl,
    input  logic [ROWS*SUBS-1:0]          collapse,
    input  logic [ROWS-1:0]               rwl,
    input  logic [ROWS-1:0]               foot_low,
    input  logic                          prech,
    input  logic [SUB_W-1:0]              wdata,
    output logic [SUBS-1:0][SUB_W-1:0]    rbl
);
    localparam int WORDS = ROWS * SUBS;

    logic [WORDS-1:0][SUB_W-1:0] pull_dn;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [SUB_W-1:0] word_q;
        // data settles once the supply is restored, second phase
        always_ff @(posedge clk) begin
            if (wwl[g] && !collapse[g]) word_q <= wdata;
        end
        assign pull_dn[g] = (rwl[g/SUBS] && foot_low[g/SUBS]) ? ~word_q : '0;
    end

    always_comb begin
        for (int s = 0; s < SUBS; s++) begin
            logic [SUB_W-1:0] low;
            low = '0;
            for (int r = 0; r < ROWS; r++) low = low | pull_dn[r*SUBS+s];
            rbl[s] = prech ? '1 : ~low;
        end
    end
endmodule

// File: rtl/sra_access_top.sv
module sra_access_top #(
    parameter int ROWS  = 16,
    parameter int SUBS  = 2,
    parameter int SUB_W = 8,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int SEL_W = (SUBS > 1) ? $clog2(SUBS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_vld,
    input  logic                  req_wr,
    input  logic [ROW_W-1:0]      row_addr,
    input  logic [SEL_W-1:0]      sub_sel,
    input  logic [SUB_W-1:0]      wdata,
    output logic [ROWS*SUBS-1:0]  wwl_o,
    output logic [ROWS*SUBS-1:0]  collapse_o,
    output logic [ROWS-1:0]       rwl_o,
    output logic [ROWS-1:0]       foot_low_o,
    output logic                  prech_o,
    output logic [SUB_W-1:0]      rdata_o,
    output logic                  rvalid_o
);
    logic             ph_first, ph_eval, op_wr;
    logic [ROW_W-1:0] row_q;
    logic [SEL_W-1:0] sub_q;
    logic [SUB_W-1:0] wdata_q;
    logic [SUB_W-1:0] rbl_sel;
    logic [SUBS-1:0][SUB_W-1:0] rbl;
    logic [ROWS-1:0]  row_hot;
    logic [SUBS-1:0]  sub_hot;
    logic             wr_act, col_act, rd_act;

    sra_phase_seq #(.ROW_W(ROW_W), .SEL_W(SEL_W), .SUB_W(SUB_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
        .row_addr(row_addr), .sub_sel(sub_sel), .wdata(wdata),
        .rbl_sel(rbl_sel), .ph_first(ph_first), .ph_eval(ph_eval),
        .op_wr(op_wr), .row_q(row_q), .sub_q(sub_q), .wdata_q(wdata_q),
        .rdata(rdata_o), .rvalid(rvalid_o)
    );

    assign wr_act  = op_wr && (ph_first || ph_eval);
    assign col_act = op_wr && ph_first;
    assign rd_act  = !op_wr && ph_eval;

    // shared row decode, per-sub-row gating
    sra_onehot_dec #(.N(ROWS), .IW(ROW_W)) u_row_dec (
        .en(wr_act || rd_act), .idx(row_q), .hot(row_hot));
    sra_onehot_dec #(.N(SUBS), .IW(SEL_W)) u_sub_dec (
        .en(wr_act), .idx(sub_q), .hot(sub_hot));

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar s = 0; s < SUBS; s++) begin : g_sub
            assign wwl_o[r*SUBS+s]      = wr_act  && row_hot[r] && sub_hot[s];
            assign collapse_o[r*SUBS+s] = col_act && row_hot[r] && sub_hot[s];
        end
        assign rwl_o[r]      = rd_act && row_hot[r];
        assign foot_low_o[r] = rd_act && row_hot[r];
    end

    assign prech_o = !(wr_act || rd_act);
    assign rbl_sel = rbl[sub_q];

    sra_cell_array #(.ROWS(ROWS), .SUBS(SUBS), .SUB_W(SUB_W)) u_array (
        .clk(clk), .wwl(wwl_o), .collapse(collapse_o), .rwl(rwl_o),
        .foot_low(foot_low_o), .prech(prech_o), .wdata(wdata_q), .rbl(rbl)
    );

    // R4
    prech_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prech_o && ((|wwl_o) || (|rwl_o))));
    // R5
    single_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wwl_o) && $onehot0(rwl_o) && $onehot0(foot_low_o) && $onehot0(collapse_o));
    // R2
    collapse_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|collapse_o) |=> ((wwl_o == $past(wwl_o)) && !(|collapse_o)));
    // R6
    foot_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (foot_low_o == rwl_o) && !((|foot_low_o) && (|wwl_o)));
    // R7
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> ($past(|rwl_o) && !(|rwl_o)));
endmodule

// File: tb/sim_sra_access_top.sv
module sim_sra_access_top;
    localparam int ROWS  = 16;
    localparam int SUBS  = 2;
    localparam int SUB_W = 8;
    localparam int ROW_W = 4;
    localparam int SEL_W = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_vld = 1'b0, req_wr = 1'b0;
    logic [ROW_W-1:0] row_addr = '0;
    logic [SEL_W-1:0] sub_sel = '0;
    logic [SUB_W-1:0] wdata = '0;
    logic [ROWS*SUBS-1:0] wwl, coll;
    logic [ROWS-1:0] rwl, foot;
    logic prech, rvalid;
    logic [SUB_W-1:0] rdata;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;
    logic [SUB_W-1:0] model [ROWS][SUBS];

    always #5 clk = ~clk;

    sra_access_top #(.ROWS(ROWS), .SUBS(SUBS), .SUB_W(SUB_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
        .row_addr(row_addr), .sub_sel(sub_sel), .wdata(wdata),
        .wwl_o(wwl), .collapse_o(coll), .rwl_o(rwl), .foot_low_o(foot),
        .prech_o(prech), .rdata_o(rdata), .rvalid_o(rvalid));

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL R11 watchdog act=%0d exp=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_chk(input string tag);
        cmp(tag, 64'(wwl), 0); cmp(tag, 64'(coll), 0);
        cmp(tag, 64'(rwl), 0); cmp(tag, 64'(foot), 0);
        cmp(tag, 64'(prech), 1);
    endtask

    // one access with an idle clock after it; inject = poke a write in first phase
    task automatic access(input bit wr, input int r, input int s,
                          input logic [SUB_W-1:0] d, input bit inject);
        int idx;
        idx = r*SUBS + s;
        @(negedge clk);
        req_vld = 1'b1; req_wr = wr; row_addr = ROW_W'(r); sub_sel = SEL_W'(s); wdata = d;
        @(negedge clk);                       // first phase
        req_vld = 1'b0;
        if (inject) begin
            req_vld = 1'b1; req_wr = 1'b1; row_addr = ROW_W'((r+1) % ROWS);
            sub_sel = SEL_W'(s); wdata = ~model[(r+1) % ROWS][s];
        end
        if (wr) begin
            cmp("R2 wwl first", 64'(wwl), 64'(1) << idx);
            cmp("R2 collapse first", 64'(coll), 64'(1) << idx);
            cmp("R6 foot on write", 64'(foot), 0);
            cmp("R4 prech on write", 64'(prech), 0);
        end else begin
            cmp("R3 prech first", 64'(prech), 1);
            cmp("R3 rwl first", 64'(rwl), 0);
            cmp("R3 wwl first", 64'(wwl), 0);
        end
        @(negedge clk);                       // evaluate phase
        req_vld = 1'b0;
        if (wr) begin
            cmp("R2 wwl second", 64'(wwl), 64'(1) << idx);
            cmp("R2 collapse second", 64'(coll), 0);
            cmp("R4 prech second", 64'(prech), 0);
        end else begin
            cmp("R3 rwl eval", 64'(rwl), 64'(1) << r);
            cmp("R6 foot eval", 64'(foot), 64'(1) << r);
            cmp("R3 prech eval", 64'(prech), 0);
            cmp("R5 no wwl on read", 64'(wwl), 0);
        end
        @(negedge clk);                       // after evaluate
        if (wr) begin
            model[r][s] = d;
            cmp("R7 no valid on write", 64'(rvalid), 0);
        end else begin
            cmp("R7 rvalid", 64'(rvalid), 1);
            cmp("R7 rdata", 64'(rdata), 64'(model[r][s]));
        end
        idle_chk(inject ? "R10 ignored" : "R9 idle");
        @(negedge clk);
        cmp("R7 single pulse", 64'(rvalid), 0);
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int s = 0; s < SUBS; s++) model[r][s] = '0;
        #23 rst_n = 1'b1;
        @(negedge clk);
        idle_chk("R1 reset");
        cmp("R1 rvalid", 64'(rvalid), 0);
        repeat (3) @(negedge clk);
        idle_chk("R9 no request");

        // R8 sweep: every sub-row written with a distinct pattern
        for (int r = 0; r < ROWS; r++)
            for (int s = 0; s < SUBS; s++)
                access(1'b1, r, s, SUB_W'((r*37 + s*101 + 5) & 255), 1'b0);
        for (int r = 0; r < ROWS; r++)
            for (int s = 0; s < SUBS; s++)
                access(1'b0, r, s, '0, 1'b0);

        // R8 partial rewrite: sub-row 0 only, sub-row 1 must survive
        for (int r = 0; r < ROWS; r += 3)
            access(1'b1, r, 0, ~model[r][0], 1'b0);
        for (int r = 0; r < ROWS; r++)
            for (int s = 0; s < SUBS; s++)
                access(1'b0, r, s, '0, 1'b0);
        access(1'b1, 5, 1, 8'h00, 1'b0);
        access(1'b1, 6, 0, 8'hFF, 1'b0);
        access(1'b0, 5, 1, '0, 1'b0);
        access(1'b0, 6, 0, '0, 1'b0);

        // R10: write poked only during a first phase must not land
        access(1'b0, 2, 1, '0, 1'b1);
        access(1'b0, 3, 1, '0, 1'b0);
        access(1'b0, ROWS-1, 1, '0, 1'b1);
        access(1'b0, 0, 1, '0, 1'b0);

        // R11: write chained straight into a read of the same word
        @(negedge clk);
        req_vld = 1'b1; req_wr = 1'b1; row_addr = 4'd9; sub_sel = 1'b1; wdata = 8'hA5;
        @(negedge clk);
        req_vld = 1'b0;
        @(negedge clk);                       // write evaluate phase
        req_vld = 1'b1; req_wr = 1'b0;
        @(negedge clk);                       // read first phase, no gap
        req_vld = 1'b0;
        model[9][1] = 8'hA5;
        cmp("R11 chained prech", 64'(prech), 1);
        cmp("R11 chained wwl off", 64'(wwl), 0);
        @(negedge clk);
        cmp("R11 chained rwl", 64'(rwl), 64'(1) << 9);
        @(negedge clk);
        cmp("R11 chained rvalid", 64'(rvalid), 1);
        cmp("R11 chained rdata", 64'(rdata), 64'h A5);
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule